// File: doc/BRIEF.md
# Freefall and Motion Event Detector

This block watches a stream of signed three-axis acceleration samples, each marked by a one-cycle valid strobe, and decides whether the stream shows a freefall or a motion event. Every axis is reduced to its magnitude and compared against a programmable limit. In freefall mode the condition holds only when every enabled axis sits below the limit. In motion mode a single enabled axis above the limit is enough.

A raw condition becomes an event only after it has held for a programmed number of consecutive samples. On the sample where that count is reached, the block records which axes took part and the sign of each of those axes. The event flag and the recorded axis bits then either track the live qualified condition or stay set until software reads the result. The interrupt request follows the event flag.

The detector feeds an interrupt controller. Its configuration comes from registers that sit elsewhere in the design.

Top module: `ffmt_detect`

## Requirements
- R1: While reset is asserted, and after it is released, `evt_flag`, `irq`, `axis_hit` and `axis_neg` are all zero.
- R2: In motion mode (`cfg_motion`=1), a sample meets the condition when at least one enabled axis has |value| > `cfg_thresh`*64. A value exactly equal to the limit does not meet it.
- R3: In freefall mode (`cfg_motion`=0), a sample meets the condition only when every enabled axis has |value| < `cfg_thresh`*64. Disabled axes are ignored. When no axis is enabled, neither mode ever meets the condition. Axis enable bit 0 is X, bit 1 is Y and bit 2 is Z.
- R4: The event is raised on the Nth consecutive valid sample that meets the condition, where N = `cfg_dbnc`, and a setting of 0 behaves as 1. Any valid sample that fails the condition restarts the count. Outputs change at the clock edge that accepts the sample.
- R5: The consecutive-sample counter saturates instead of wrapping. A condition that lasts longer than 255 samples therefore keeps the event asserted.
- R6: On the sample where the count is reached, `axis_hit` (bit 0 X, 1 Y, 2 Z) captures the axes that took part. In motion mode these are the enabled axes above the limit; in freefall mode they are all enabled axes. `axis_neg` captures the sign bit of each hit axis, and is 0 for every axis not hit.
- R7: With `cfg_latch`=0, `evt_flag` and the axis bits clear on the first valid sample whose debounced condition is false, and `src_read` has no effect.
- R8: With `cfg_latch`=1, `evt_flag` and the axis bits hold until a `src_read` pulse clears them. If a new event is reached in the same cycle as a read, the new event wins.
- R9: While `smp_valid` is low, sample inputs have no effect on any output.
- R10: `irq` equals `evt_flag` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | One-cycle strobe marking a new sample |
| smp_x | input | 12 | X sample, two's complement |
| smp_y | input | 12 | Y sample, two's complement |
| smp_z | input | 12 | Z sample, two's complement |
| cfg_motion | input | 1 | 1 selects motion mode, 0 selects freefall mode |
| cfg_axis_en | input | 3 | Axis enables (bit 0 X, bit 1 Y, bit 2 Z) |
| cfg_latch | input | 1 | 1 holds results until they are read |
| cfg_thresh | input | 7 | Limit in steps of 64 counts |
| cfg_dbnc | input | 8 | Number of consecutive samples required |
| src_read | input | 1 | One-cycle pulse that reads and clears latched results |
| evt_flag | output | 1 | Event flag |
| axis_hit | output | 3 | Axes that caused the event |
| axis_neg | output | 3 | Sign of each axis that caused the event |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that configuration inputs stay constant within a run of consecutive samples, and that `smp_valid` and `src_read` are single-cycle pulses that are sampled synchronously. The bench changes configuration only on a sample that breaks the current run, or right after a reset. It drives every strobe for exactly one clock, on the falling edge, and samples the outputs one falling edge later. The sample values include the equality edge of the limit, the most negative code, and a run longer than the counter range, so that the comparison and saturation corners are covered.

// File: rtl/ffmt_pkg.sv
package ffmt_pkg;
  localparam int NUM_AXES = 3;
  typedef enum logic {MODE_FREEFALL = 1'b0, MODE_MOTION = 1'b1} mode_e;
endpackage

// File: rtl/ffmt_axis_cmp.sv
module ffmt_axis_cmp #(
  parameter int DATA_W    = 12,
  parameter int THR_W     = 7,
  parameter int THR_SHIFT = 6
) (
  input  logic [DATA_W-1:0] sample,
  input  logic [THR_W-1:0]  thresh,
  output logic              above,
  output logic              below,
  output logic              sign
);
  localparam int MAG_W = DATA_W + 1;
  localparam int LIM_W = THR_W + THR_SHIFT;
  localparam int CMP_W = ((MAG_W > LIM_W) ? MAG_W : LIM_W) + 1;

  logic [MAG_W-1:0] ext;
  logic [MAG_W-1:0] mag;
  logic [CMP_W-1:0] mag_c;
  logic [CMP_W-1:0] lim_c;

  always_comb begin
    ext   = {sample[DATA_W-1], sample};
    mag   = sample[DATA_W-1] ? (MAG_W'(0) - ext) : ext;
    mag_c = CMP_W'(mag);
    lim_c = CMP_W'({thresh, {THR_SHIFT{1'b0}}});
    above = mag_c > lim_c;
    below = mag_c < lim_c;
    sign  = sample[DATA_W-1];
  end
endmodule

// File: rtl/ffmt_debounce.sv
module ffmt_debounce #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic             cond,
  input  logic [CNT_W-1:0] dbnc,
  output logic             reach,
  output logic             qual_nx
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   cnt_inc;
  logic [CNT_W:0]   need;

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    need    = (dbnc == '0) ? (CNT_W+1)'(1) : {1'b0, dbnc};
    qual_nx = cond && (cnt_inc >= need);
    reach   = valid && cond && (cnt_inc == need);
    cnt_d   = cnt_q;
    if (valid) begin
      if (!cond)               cnt_d = '0;
      else if (cnt_q != CNT_MAX) cnt_d = cnt_inc[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (valid) cnt_q <= cnt_d;
  end

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !cond) |=> (cnt_q == '0)); // R4
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(cnt_q)); // R9
  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && cond && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R5
endmodule

// File: rtl/ffmt_source.sv
module ffmt_source #(
  parameter int NAX = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           valid,
  input  logic           reach,
  input  logic           qual_nx,
  input  logic           latch,
  input  logic           rd,
  input  logic [NAX-1:0] hit_in,
  input  logic [NAX-1:0] neg_in,
  output logic           evt,
  output logic [NAX-1:0] hit,
  output logic [NAX-1:0] neg
);
  logic           evt_d;
  logic [NAX-1:0] hit_d, neg_d;
  logic           upd;

  always_comb begin
    evt_d = evt;
    hit_d = hit;
    neg_d = neg;
    if (reach) begin
      evt_d = 1'b1;
      hit_d = hit_in;
      neg_d = neg_in;
    end else if (latch ? rd : (valid && !qual_nx)) begin
      evt_d = 1'b0;
      hit_d = '0;
      neg_d = '0;
    end
    upd = reach || rd || valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt <= 1'b0;
      hit <= '0;
      neg <= '0;
    end else if (upd) begin
      evt <= evt_d;
      hit <= hit_d;
      neg <= neg_d;
    end
  end

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && evt && !rd && !reach) |=> evt); // R8
  AST_REACH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    reach |=> evt); // R6
  AST_NEG_IN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    reach |-> ((neg_in & ~hit_in) == '0)); // R6
endmodule

// File: rtl/ffmt_detect.sv
module ffmt_detect #(
  parameter int DATA_W    = 12,
  parameter int THR_W     = 7,
  parameter int THR_SHIFT = 6,
  parameter int CNT_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_x,
  input  logic [DATA_W-1:0] smp_y,
  input  logic [DATA_W-1:0] smp_z,
  input  logic              cfg_motion,
  input  logic [2:0]        cfg_axis_en,
  input  logic              cfg_latch,
  input  logic [THR_W-1:0]  cfg_thresh,
  input  logic [CNT_W-1:0]  cfg_dbnc,
  input  logic              src_read,
  output logic              evt_flag,
  output logic [2:0]        axis_hit,
  output logic [2:0]        axis_neg,
  output logic              irq
);
  import ffmt_pkg::*;

  logic [NUM_AXES-1:0][DATA_W-1:0] smp_all;
  logic [NUM_AXES-1:0] above, below, sgn;
  logic [NUM_AXES-1:0] hit_in, neg_in;
  logic                cond, reach, qual_nx;
  mode_e               mode;

  assign smp_all = {smp_z, smp_y, smp_x};

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
    ffmt_axis_cmp #(
      .DATA_W(DATA_W), .THR_W(THR_W), .THR_SHIFT(THR_SHIFT)
    ) u_cmp (
      .sample(smp_all[a]),
      .thresh(cfg_thresh),
      .above (above[a]),
      .below (below[a]),
      .sign  (sgn[a])
    );
  end

  always_comb begin
    mode = cfg_motion ? MODE_MOTION : MODE_FREEFALL;
    if (mode == MODE_MOTION) begin
      hit_in = above & cfg_axis_en;
      cond   = |hit_in;
    end else begin
      hit_in = cfg_axis_en;
      cond   = (|cfg_axis_en) && (&(below | ~cfg_axis_en));
    end
    neg_in = hit_in & sgn;
  end

  ffmt_debounce #(.CNT_W(CNT_W)) u_dbnc (
    .clk    (clk),
    .rst_n  (rst_n),
    .valid  (smp_valid),
    .cond   (cond),
    .dbnc   (cfg_dbnc),
    .reach  (reach),
    .qual_nx(qual_nx)
  );

  ffmt_source #(.NAX(NUM_AXES)) u_src (
    .clk    (clk),
    .rst_n  (rst_n),
    .valid  (smp_valid),
    .reach  (reach),
    .qual_nx(qual_nx),
    .latch  (cfg_latch),
    .rd     (src_read),
    .hit_in (hit_in),
    .neg_in (neg_in),
    .evt    (evt_flag),
    .hit    (axis_hit),
    .neg    (axis_neg)
  );

  assign irq = evt_flag;

  AST_NOLATCH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !cfg_latch && !cond) |=> !evt_flag); // R7
  AST_NO_AXES_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && cfg_axis_en == 3'b000) |-> !reach); // R3
  AST_HIT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    reach |-> ((hit_in & ~cfg_axis_en) == 3'b000)); // R6
endmodule

// File: tb/ffmt_detect_tb.sv
module ffmt_detect_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [11:0] x, y, z;
    logic        mot;
    logic [2:0]  en;
    logic [6:0]  thr;
    logic [7:0]  dbnc;
    logic        evt;
    logic [2:0]  hit, neg;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{12'd1100,  12'd0,    12'd0,    1'b1, 3'b111, 7'd16, 8'd3, 1'b0, 3'b000, 3'b000},
    '{-12'sd1100, 12'd0,   12'd0,    1'b1, 3'b111, 7'd16, 8'd3, 1'b0, 3'b000, 3'b000},
    '{12'd0,     12'd2000, 12'd0,    1'b1, 3'b111, 7'd16, 8'd3, 1'b1, 3'b010, 3'b000},
    '{12'd1024,  12'd0,    12'd0,    1'b1, 3'b111, 7'd16, 8'd3, 1'b0, 3'b000, 3'b000},
    '{12'd100,   -12'sd200, 12'd50,  1'b0, 3'b111, 7'd4,  8'd2, 1'b0, 3'b000, 3'b000},
    '{-12'sd255, 12'd0,    12'd255,  1'b0, 3'b111, 7'd4,  8'd2, 1'b1, 3'b111, 3'b001},
    '{12'd256,   12'd0,    12'd0,    1'b0, 3'b111, 7'd4,  8'd2, 1'b0, 3'b000, 3'b000},
    '{12'd10,    -12'sd10, 12'd2000, 1'b0, 3'b011, 7'd4,  8'd1, 1'b1, 3'b011, 3'b010},
    '{12'd2000,  12'd2000, 12'd0,    1'b1, 3'b100, 7'd4,  8'd1, 1'b0, 3'b000, 3'b000},
    '{12'd2000,  12'd2000, -12'sd300, 1'b1, 3'b100, 7'd4, 8'd1, 1'b1, 3'b100, 3'b100},
    '{12'd2000,  12'd0,    12'd0,    1'b1, 3'b000, 7'd4,  8'd1, 1'b0, 3'b000, 3'b000},
    '{12'h800,   12'd0,    12'd0,    1'b1, 3'b001, 7'd4,  8'd0, 1'b1, 3'b001, 3'b001}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic smp_valid, cfg_motion, cfg_latch, src_read;
  logic [11:0] smp_x, smp_y, smp_z;
  logic [2:0] cfg_axis_en;
  logic [6:0] cfg_thresh;
  logic [7:0] cfg_dbnc;
  logic evt_flag, irq;
  logic [2:0] axis_hit, axis_neg;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ffmt_detect u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
    .cfg_motion(cfg_motion), .cfg_axis_en(cfg_axis_en), .cfg_latch(cfg_latch),
    .cfg_thresh(cfg_thresh), .cfg_dbnc(cfg_dbnc), .src_read(src_read),
    .evt_flag(evt_flag), .axis_hit(axis_hit), .axis_neg(axis_neg), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] exp);
    logic [7:0] act;
    act = {irq, evt_flag, axis_hit, axis_neg};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {irq,evt,hit,neg} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic sample(input logic [11:0] x, y, z, input logic rd);
    @(negedge clk);
    smp_x = x; smp_y = y; smp_z = z;
    smp_valid = 1'b1; src_read = rd;
    @(negedge clk);
    smp_valid = 1'b0; src_read = 1'b0;
  endtask

  task automatic pulse_read();
    @(negedge clk);
    src_read = 1'b1;
    @(negedge clk);
    src_read = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; smp_valid = 0; src_read = 0;
    smp_x = '0; smp_y = '0; smp_z = '0;
    cfg_motion = 0; cfg_axis_en = '0; cfg_latch = 0; cfg_thresh = '0; cfg_dbnc = '0;
    repeat (2) @(negedge clk);
    chk("R1 in reset", 8'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", 8'b0);

    // table walk: R2 R3 R4 R6 R7 R10
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cfg_motion = VEC[i].mot; cfg_axis_en = VEC[i].en;
      cfg_thresh = VEC[i].thr; cfg_dbnc = VEC[i].dbnc;
      sample(VEC[i].x, VEC[i].y, VEC[i].z, 1'b0);
      chk($sformatf("R2 R3 R4 R6 R10 vector %0d", i),
          {VEC[i].evt, VEC[i].evt, VEC[i].hit, VEC[i].neg});
    end

    do_reset();
    chk("R1 re-reset", 8'b0);
    cfg_latch = 1; cfg_motion = 1; cfg_axis_en = 3'b001; cfg_thresh = 7'd4; cfg_dbnc = 8'd1;
    sample(12'd500, 12'd0, 12'd0, 1'b0);
    chk("R8 latched set", 8'b11_001_000);
    sample(12'd0, 12'd0, 12'd0, 1'b0);
    chk("R8 held after failing sample", 8'b11_001_000);
    pulse_read();
    chk("R8 read clears", 8'b0);

    cfg_latch = 0;
    sample(12'd500, 12'd0, 12'd0, 1'b0);
    chk("R7 live set", 8'b11_001_000);
    pulse_read();
    chk("R7 read ignored", 8'b11_001_000);

    @(negedge clk);
    smp_x = 12'd0;
    repeat (5) @(negedge clk);
    chk("R9 no valid no change", 8'b11_001_000);

    cfg_latch = 1;
    sample(12'd0, 12'd0, 12'd0, 1'b0);
    chk("R8 hold", 8'b11_001_000);
    pulse_read();
    sample(-12'sd600, 12'd0, 12'd0, 1'b1);
    chk("R8 reach beats read", 8'b11_001_001);

    cfg_latch = 0; cfg_dbnc = 8'd255;
    sample(12'd0, 12'd0, 12'd0, 1'b0);
    chk("R7 cleared by failing sample", 8'b0);
    for (int k = 0; k < 254; k++) sample(12'd500, 12'd0, 12'd0, 1'b0);
    chk("R4 not yet at 254", 8'b0);
    sample(12'd500, 12'd0, 12'd0, 1'b0);
    chk("R4 reached at 255", 8'b11_001_000);
    for (int k = 0; k < 300; k++) sample(12'd500, 12'd0, 12'd0, 1'b0);
    chk("R5 saturated, still set", 8'b11_001_000);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule